// File: doc/BRIEF.md
# Bit-Band Alias Address Translator

This block sits between a bus master port and a byte-addressable memory. It watches every request for an address inside an alias window, where each 32-bit alias word stands for one bit of a byte in a target window. An alias word lives at `ALIAS_BASE + byteIndex*32 + bitIndex*4`. The byte index counts bytes from `TGT_BASE`, and the bit index runs from 0 to 7. For example, bit 2 of target byte `0x20000300` has its alias word at `0x22006008`.

An alias read fetches the word that holds the target byte and answers `0x00000001` or `0x00000000`. An alias write turns into a locked read then write-back of that one byte. Bit 0 of the write data sets the chosen bit, and the other seven bits of the byte keep their values. No new request is accepted until the write-back has finished.

Only requests tagged as coming from the processor are translated. Any other master that hits the alias window gets an error response, as does any processor alias access that is not a word-aligned word access, and none of these touches memory. Every request outside the alias window is forwarded to memory unchanged. The memory takes one request per cycle and returns read data in the cycle after the read strobe.

Top module: `bitband_xlate`

## Requirements
- R1: After reset, with no request pending, `reqReady` is 1, `rspValid` is 0, and both `memRd` and `memWr` are 0.
- R2: A request outside the alias window passes through unchanged, from any master:
  - The memory address is the request address with bits [1:0] cleared.
  - Write data goes through unchanged.
  - Byte enables follow `reqSize` and the low address bits. Size 0 is a byte access and enables lane `addr[1:0]`. Size 1 is a half-word and enables lanes {`addr[1]`*2, +1}. Size 2 is a word and enables all four lanes.
  - A write responds 1 cycle after acceptance.
  - A read responds 2 cycles after acceptance with the addressed memory word.
- R3: An address A with `ALIAS_BASE <= A < ALIAS_BASE + 2^(TGT_AW+5)` selects a target byte and a bit:
  - The target byte is `TGT_BASE + ((A-ALIAS_BASE)>>5)`.
  - The bit is `(A>>2) & 7`.
  - The top alias word of the window maps to bit 7 of the last target byte.
  - The first address past the window is a normal pass-through access.
- R4: A processor alias read responds 2 cycles after acceptance, with error 0 and data `0x00000001` if the target bit is 1, or `0x00000000` if it is 0.
- R5: A processor alias write runs in three steps:
  - It reads the word that holds the target byte.
  - Two cycles after acceptance it writes that byte back, with exactly one byte enable set. Only the target bit changes, and it takes the value of `reqWdata[0]`.
  - It responds 3 cycles after acceptance, with error 0 and data 0.
- R6: `reqReady` is 0 from the cycle after acceptance through the response cycle, and it is 1 again in the cycle after the response.
- R7: An alias-window access tagged as non-processor (`reqIsCpu`=0) raises no memory strobe. It responds 1 cycle after acceptance with `rspErr`=1 and leaves memory contents unchanged.
- R8: A processor alias access with `reqSize` other than 2, or with a byte offset inside the word other than 0, is refused in the same way as in R7.
- R9: `rspValid` is a single-cycle pulse per request. An error response, a pass-through write response and an alias write response all carry data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle when high with reqValid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqIsCpu | input | 1 | Request tagged as coming from the processor |
| reqSize | input | 2 | 0 byte, 1 half-word, 2 word |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | 32 | Write data, lane-positioned |
| rspValid | output | 1 | Response pulse |
| rspErr | output | 1 | Response is an error |
| rspRdata | output | 32 | Response data |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Word-aligned memory address |
| memBe | output | 4 | Byte enables for writes |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid the cycle after memRd |

## Verification
A wrong saved lane or bit index does not show up in the alias write's own response, which carries no data. It shows only later, as a wrong bit in another byte when that byte is read back through a plain pass-through or alias read. For that reason every alias write is followed by read-back of the whole word. A sequencing fault that drops or shortens the locked phase shows up at once at the ports: `reqReady` returns too early, or the response arrives in the wrong cycle. Both are checked on every cycle of every transaction. A misrouted refusal shows up as a memory strobe or a changed word.

// File: rtl/bb_pkg.sv
package bb_pkg;

  localparam int DATA_W  = 32;
  localparam int LANES   = DATA_W / 8;

  localparam logic [1:0] SIZE_BYTE = 2'd0;
  localparam logic [1:0] SIZE_HALF = 2'd1;
  localparam logic [1:0] SIZE_WORD = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS_RD,
    ST_ALIAS_RD,
    ST_ALIAS_WB,
    ST_RESP
  } bbState_t;

  typedef struct packed {
    logic latchReq;
    logic issueRd;
    logic issueWr;
    logic writeBack;
    logic capPass;
    logic capAlias;
  } bbCtl_t;

endpackage

// File: rtl/bb_decode.sv
module bb_decode
  import bb_pkg::*;
#(
  parameter int               ADDR_W     = 32,
  parameter int               TGT_AW     = 15,
  parameter logic [ADDR_W-1:0] TGT_BASE   = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h2200_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              isCpu,
  output logic              aliasHit,
  output logic              aliasBad,
  output logic [ADDR_W-1:0] tgtWordAddr,
  output logic [1:0]        tgtLane,
  output logic [2:0]        tgtBit,
  output logic [ADDR_W-1:0] passWordAddr,
  output logic [LANES-1:0]  passBe
);

  localparam int OFF_W = TGT_AW + 5;

  logic [ADDR_W-1:0] offset;
  logic [TGT_AW-1:0] byteIdx;
  logic [ADDR_W-1:0] tgtByte;

  assign offset   = addr - ALIAS_BASE;
  assign aliasHit = (offset[ADDR_W-1:OFF_W] == '0);
  assign byteIdx  = offset[OFF_W-1:5];
  assign tgtBit   = offset[4:2];
  assign tgtByte  = TGT_BASE + {{(ADDR_W-TGT_AW){1'b0}}, byteIdx};
  assign tgtLane  = tgtByte[1:0];
  assign tgtWordAddr  = {tgtByte[ADDR_W-1:2], 2'b00};
  assign passWordAddr = {addr[ADDR_W-1:2], 2'b00};

  assign aliasBad = aliasHit &&
                    (!isCpu || (size != SIZE_WORD) || (offset[1:0] != 2'b00));

  always_comb begin
    unique case (size)
      SIZE_BYTE: passBe = 4'b0001 << addr[1:0];
      SIZE_HALF: passBe = 4'b0011 << {addr[1], 1'b0};
      default:   passBe = 4'b1111;
    endcase
  end

endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl
  import bb_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqWrite,
  input  logic   aliasHit,
  input  logic   aliasBad,
  output logic   reqReady,
  output logic   rspValid,
  output bbCtl_t ctl
);

  bbState_t state, stateNext;
  logic     wrFlag;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.latchReq = 1'b1;
          if (aliasBad) begin
            stateNext = ST_RESP;
          end else if (aliasHit) begin
            ctl.issueRd = 1'b1;
            stateNext   = ST_ALIAS_RD;
          end else if (reqWrite) begin
            ctl.issueWr = 1'b1;
            stateNext   = ST_RESP;
          end else begin
            ctl.issueRd = 1'b1;
            stateNext   = ST_PASS_RD;
          end
        end
      end
      ST_PASS_RD: begin
        ctl.capPass = 1'b1;
        stateNext   = ST_RESP;
      end
      ST_ALIAS_RD: begin
        ctl.capAlias = 1'b1;
        stateNext    = wrFlag ? ST_ALIAS_WB : ST_RESP;
      end
      ST_ALIAS_WB: begin
        ctl.issueWr   = 1'b1;
        ctl.writeBack = 1'b1;
        stateNext     = ST_RESP;
      end
      ST_RESP:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      wrFlag <= 1'b0;
    end else begin
      state <= stateNext;
      if (ctl.latchReq) wrFlag <= reqWrite;
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign rspValid = (state == ST_RESP);

endmodule

// File: rtl/bb_datapath.sv
module bb_datapath
  import bb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  bbCtl_t            ctl,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              aliasHit,
  input  logic              aliasBad,
  input  logic [ADDR_W-1:0] tgtWordAddr,
  input  logic [1:0]        tgtLane,
  input  logic [2:0]        tgtBit,
  input  logic [ADDR_W-1:0] passWordAddr,
  input  logic [LANES-1:0]  passBe,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memRd,
  output logic              memWr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memBe,
  output logic [DATA_W-1:0] memWdata,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspRdata
);

  logic [ADDR_W-1:0] wbAddr;
  logic [1:0]        wbLane;
  logic [2:0]        wbBit;
  logic              wbVal;
  logic              wasWrite;
  logic [7:0]        wbByte;
  logic [7:0]        newByte;
  logic [7:0]        rdLane [LANES];
  logic [7:0]        laneByte;
  logic [DATA_W-1:0] rspData;
  logic              errR;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rdLane[g] = memRdata[8*g +: 8];
  end

  assign laneByte = rdLane[wbLane];

  always_comb begin
    newByte        = wbByte;
    newByte[wbBit] = wbVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbAddr   <= '0;
      wbLane   <= '0;
      wbBit    <= '0;
      wbVal    <= 1'b0;
      wasWrite <= 1'b0;
      wbByte   <= '0;
      rspData  <= '0;
      errR     <= 1'b0;
    end else begin
      if (ctl.latchReq) begin
        wbAddr   <= tgtWordAddr;
        wbLane   <= tgtLane;
        wbBit    <= tgtBit;
        wbVal    <= reqWdata[0];
        wasWrite <= reqWrite;
        rspData  <= '0;
        errR     <= aliasBad;
      end
      if (ctl.capPass) rspData <= memRdata;
      if (ctl.capAlias) begin
        wbByte <= laneByte;
        if (!wasWrite) rspData <= {{(DATA_W-1){1'b0}}, laneByte[wbBit]};
      end
    end
  end

  assign memRd    = ctl.issueRd;
  assign memWr    = ctl.issueWr;
  assign memAddr  = ctl.writeBack ? wbAddr
                  : (aliasHit ? tgtWordAddr : passWordAddr);
  assign memBe    = ctl.writeBack ? (4'b0001 << wbLane)
                  : (aliasHit ? 4'b1111 : passBe);
  assign memWdata = ctl.writeBack ? {LANES{newByte}} : reqWdata;
  assign rspErr   = errR;
  assign rspRdata = rspData;

endmodule

// File: rtl/bitband_xlate.sv
module bitband_xlate
  import bb_pkg::*;
#(
  parameter int               ADDR_W     = 32,
  parameter int               TGT_AW     = 15,
  parameter logic [ADDR_W-1:0] TGT_BASE   = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h2200_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic              reqIsCpu,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              rspValid,
  output logic              rspErr,
  output logic [31:0]       rspRdata,
  output logic              memRd,
  output logic              memWr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        memBe,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata
);

  logic              aliasHit;
  logic              aliasBad;
  logic [ADDR_W-1:0] tgtWordAddr;
  logic [1:0]        tgtLane;
  logic [2:0]        tgtBit;
  logic [ADDR_W-1:0] passWordAddr;
  logic [LANES-1:0]  passBe;
  bbCtl_t            ctl;

  bb_decode #(
    .ADDR_W(ADDR_W), .TGT_AW(TGT_AW),
    .TGT_BASE(TGT_BASE), .ALIAS_BASE(ALIAS_BASE)
  ) u_decode (
    .addr(reqAddr), .size(reqSize), .isCpu(reqIsCpu),
    .aliasHit(aliasHit), .aliasBad(aliasBad),
    .tgtWordAddr(tgtWordAddr), .tgtLane(tgtLane), .tgtBit(tgtBit),
    .passWordAddr(passWordAddr), .passBe(passBe)
  );

  bb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite),
    .aliasHit(aliasHit), .aliasBad(aliasBad),
    .reqReady(reqReady), .rspValid(rspValid), .ctl(ctl)
  );

  bb_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqWrite(reqWrite), .reqWdata(reqWdata),
    .aliasHit(aliasHit), .aliasBad(aliasBad),
    .tgtWordAddr(tgtWordAddr), .tgtLane(tgtLane), .tgtBit(tgtBit),
    .passWordAddr(passWordAddr), .passBe(passBe),
    .memRdata(memRdata),
    .memRd(memRd), .memWr(memWr), .memAddr(memAddr),
    .memBe(memBe), .memWdata(memWdata),
    .rspErr(rspErr), .rspRdata(rspRdata)
  );

endmodule

// File: rtl/bitband_xlate_chk.sv
module bitband_xlate_chk #(
  parameter int               ADDR_W     = 32,
  parameter int               TGT_AW     = 15,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h2200_0000
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqIsCpu,
  input logic [1:0]        reqSize,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic              rspErr,
  input logic [31:0]       rspRdata,
  input logic              memRd,
  input logic              memWr,
  input logic [3:0]        memBe
);

  localparam int SPAN_W = TGT_AW + 5;

  logic [ADDR_W-1:0] relAddr;
  logic              inWindow;
  logic              accepted;

  assign relAddr  = reqAddr - ALIAS_BASE;
  assign inWindow = (relAddr >> SPAN_W) == '0;
  assign accepted = reqValid && reqReady;

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);                                            // R9
  AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr) |-> (rspRdata == 32'd0));                      // R9
  AST_BUSY_AT_RSP: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);                                            // R6
  AST_READY_AFTER_RSP: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> reqReady);                                             // R6
  AST_FOREIGN_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && inWindow && !reqIsCpu) |-> (!memRd && !memWr));        // R7
  AST_MISALIGN_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && inWindow && (reqSize != 2'd2 || relAddr[1:0] != 2'd0))
      |-> (!memRd && !memWr));                                          // R8
  AST_WB_ONE_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && !reqReady) |-> ($countones(memBe) == 1));                 // R5
  AST_WB_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && !reqReady) |-> $past(memRd, 2));                          // R5

endmodule

bind bitband_xlate bitband_xlate_chk #(
  .ADDR_W(ADDR_W), .TGT_AW(TGT_AW), .ALIAS_BASE(ALIAS_BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqIsCpu(reqIsCpu), .reqSize(reqSize), .reqAddr(reqAddr),
  .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata),
  .memRd(memRd), .memWr(memWr), .memBe(memBe)
);

// File: tb/tb_bitband_xlate.sv
module tb_bitband_xlate;

  localparam logic [31:0] AB = 32'h2200_0000;
  localparam logic [31:0] TB = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic        reqIsCpu = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid, rspErr;
  logic [31:0] rspRdata;
  logic        memRd, memWr;
  logic [31:0] memAddr, memWdata;
  logic [3:0]  memBe;
  logic [31:0] memRdata = '0;

  int nChecks = 0;
  int nFail   = 0;
  int memOps  = 0;
  bit done    = 1'b0;

  logic [31:0] mem    [8192];
  logic [31:0] refMem [8192];

  always #10 clk = ~clk;

  bitband_xlate dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqIsCpu(reqIsCpu), .reqSize(reqSize),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspValid(rspValid),
    .rspErr(rspErr), .rspRdata(rspRdata), .memRd(memRd), .memWr(memWr),
    .memAddr(memAddr), .memBe(memBe), .memWdata(memWdata),
    .memRdata(memRdata)
  );

  always @(posedge clk) begin
    if (memWr) begin
      memOps <= memOps + 1;
      for (int l = 0; l < 4; l++)
        if (memBe[l]) mem[memAddr[14:2]][8*l +: 8] <= memWdata[8*l +: 8];
    end
    if (memRd) begin
      memOps   <= memOps + 1;
      memRdata <= mem[memAddr[14:2]];
    end
  end

  function automatic logic [31:0] aliasOf(input int byteOff, input int bitNo);
    return AB + byteOff * 32 + bitNo * 4;
  endfunction

  function automatic logic [3:0] beOf(input logic [1:0] sz, input logic [31:0] a);
    if (sz == 2'd0) return 4'b0001 << a[1:0];
    if (sz == 2'd1) return a[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic refPass(input logic [31:0] a, input logic [1:0] sz,
                         input logic [31:0] d);
    logic [3:0] be = beOf(sz, a);
    for (int l = 0; l < 4; l++)
      if (be[l]) refMem[a[14:2]][8*l +: 8] = d[8*l +: 8];
  endtask

  task automatic refBit(input int byteOff, input int bitNo, input bit v);
    logic [31:0] a = TB + byteOff;
    refMem[a[14:2]][8*a[1:0] + bitNo] = v;
  endtask

  function automatic bit refGet(input int byteOff, input int bitNo);
    logic [31:0] a = TB + byteOff;
    return refMem[a[14:2]][8*a[1:0] + bitNo];
  endfunction

  task automatic xfer(input bit cpu, input bit wr, input logic [1:0] sz,
                      input logic [31:0] a, input logic [31:0] wd,
                      input bit expErr, input logic [31:0] expData,
                      input int expLat, input string req);
    int n;
    int opsBefore;
    @(negedge clk);
    chk(reqReady === 1'b1, {req, " ready before request (R6)"}, {31'd0, reqReady}, 32'd1);
    reqValid = 1'b1; reqIsCpu = cpu; reqWrite = wr; reqSize = sz;
    reqAddr = a; reqWdata = wd;
    opsBefore = memOps;
    @(negedge clk);
    reqValid = 1'b0;
    n = 1;
    while (rspValid !== 1'b1 && n < 8) begin
      chk(reqReady === 1'b0, {req, " busy while pending (R6)"}, {31'd0, reqReady}, 32'd0);
      @(negedge clk);
      n++;
    end
    chk(n == expLat, {req, " latency"}, n, expLat);
    chk(rspErr === expErr, {req, " error flag"}, {31'd0, rspErr}, {31'd0, expErr});
    chk(rspRdata === expData, {req, " data"}, rspRdata, expData);
    chk(reqReady === 1'b0, {req, " busy in response cycle (R6)"}, {31'd0, reqReady}, 32'd0);
    if (expErr) chk(memOps == opsBefore, {req, " no memory access (R7/R8)"}, memOps, opsBefore);
    @(negedge clk);
    chk(rspValid === 1'b0, {req, " response is a pulse (R9)"}, {31'd0, rspValid}, 32'd0);
    chk(reqReady === 1'b1, {req, " ready after response (R6)"}, {31'd0, reqReady}, 32'd1);
  endtask

  task automatic passRd(input logic [31:0] a, input string req);
    xfer(1'b1, 1'b0, 2'd2, a, 32'd0, 1'b0, refMem[a[14:2]], 2, req);
  endtask

  initial begin
    for (int i = 0; i < 8192; i++) begin
      mem[i] = '0;
      refMem[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady === 1'b1, "R1 reqReady", {31'd0, reqReady}, 32'd1);
    chk(rspValid === 1'b0, "R1 rspValid", {31'd0, rspValid}, 32'd0);
    chk({memRd, memWr} === 2'b00, "R1 memory strobes", {30'd0, memRd, memWr}, 32'd0);

    // R2: pass-through word write and read-back
    xfer(1'b1, 1'b1, 2'd2, TB + 32'h300, 32'hA5A5_0F0F, 1'b0, 32'd0, 1, "R2 word write");
    refPass(TB + 32'h300, 2'd2, 32'hA5A5_0F0F);
    passRd(TB + 32'h300, "R2 word read");
    // R2: byte and half-word lanes, from a non-processor master
    xfer(1'b0, 1'b1, 2'd0, TB + 32'h411, 32'h0000_5A00, 1'b0, 32'd0, 1, "R2 byte write lane 1");
    refPass(TB + 32'h411, 2'd0, 32'h0000_5A00);
    xfer(1'b0, 1'b1, 2'd1, TB + 32'h412, 32'hBEEF_0000, 1'b0, 32'd0, 1, "R2 half write upper");
    refPass(TB + 32'h412, 2'd1, 32'hBEEF_0000);
    xfer(1'b0, 1'b0, 2'd2, TB + 32'h410, 32'd0, 1'b0, refMem[(TB + 32'h410) >> 2 & 13'h1FFF], 2, "R2 non-cpu read");

    // R3/R4: bit 2 of byte 0x300 at 0x22006008
    chk(aliasOf(32'h300, 2) == 32'h2200_6008, "R3 alias formula", aliasOf(32'h300, 2), 32'h2200_6008);
    xfer(1'b1, 1'b0, 2'd2, 32'h2200_6008, 32'd0, 1'b0, 32'd1, 2, "R4 alias read set bit");
    xfer(1'b1, 1'b0, 2'd2, aliasOf(32'h300, 4), 32'd0, 1'b0, 32'd0, 2, "R4 alias read clear bit");

    // R5: set bit 7 of byte 0x301, clear bit 2 of byte 0x303
    xfer(1'b1, 1'b1, 2'd2, aliasOf(32'h301, 7), 32'hFFFF_FFFF, 1'b0, 32'd0, 3, "R5 alias set");
    refBit(32'h301, 7, 1'b1);
    xfer(1'b1, 1'b1, 2'd2, aliasOf(32'h303, 2), 32'hFFFF_FFFE, 1'b0, 32'd0, 3, "R5 alias clear");
    refBit(32'h303, 2, 1'b0);
    chk(refMem[(TB + 32'h300) >> 2 & 13'h1FFF] == 32'hA1A5_8F0F, "R5 bench model", refMem[(TB + 32'h300) >> 2 & 13'h1FFF], 32'hA1A5_8F0F);
    passRd(TB + 32'h300, "R5 neighbours preserved");
    xfer(1'b1, 1'b0, 2'd2, aliasOf(32'h303, 2), 32'd0, 1'b0, 32'd0, 2, "R4 alias read after clear");

    // R5: walk all bits of byte 0x305 with alternating values
    for (int b = 0; b < 8; b++) begin
      xfer(1'b1, 1'b1, 2'd2, aliasOf(32'h305, b), {31'd0, b[0]}, 1'b0, 32'd0, 3, "R5 bit walk write");
      refBit(32'h305, b, b[0]);
    end
    for (int b = 0; b < 8; b++)
      xfer(1'b1, 1'b0, 2'd2, aliasOf(32'h305, b), 32'd0, 1'b0, {31'd0, refGet(32'h305, b)}, 2, "R4 bit walk read");
    passRd(TB + 32'h304, "R5 bit walk word");

    // R7: non-processor alias accesses are refused
    xfer(1'b0, 1'b1, 2'd2, aliasOf(32'h300, 0), 32'd0, 1'b1, 32'd0, 1, "R7 dma alias write");
    xfer(1'b0, 1'b0, 2'd2, aliasOf(32'h300, 0), 32'd0, 1'b1, 32'd0, 1, "R7 dma alias read");
    passRd(TB + 32'h300, "R7 memory unchanged");

    // R8: misaligned or narrow processor alias accesses are refused
    xfer(1'b1, 1'b1, 2'd2, aliasOf(32'h300, 1) + 2, 32'd0, 1'b1, 32'd0, 1, "R8 misaligned write");
    xfer(1'b1, 1'b1, 2'd0, aliasOf(32'h300, 0), 32'd0, 1'b1, 32'd0, 1, "R8 byte-size write");
    xfer(1'b1, 1'b0, 2'd1, aliasOf(32'h300, 2), 32'd0, 1'b1, 32'd0, 1, "R8 half-size read");
    passRd(TB + 32'h300, "R8 memory unchanged");

    // R3: window edges
    xfer(1'b1, 1'b1, 2'd2, 32'h220F_FFFC, 32'd1, 1'b0, 32'd0, 3, "R3 top alias word");
    refBit(32'h7FFF, 7, 1'b1);
    passRd(TB + 32'h7FFC, "R3 top alias lands on last byte bit 7");
    xfer(1'b1, 1'b1, 2'd2, 32'h2210_0000, 32'h1234_5678, 1'b0, 32'd0, 1, "R3 first address past window");
    refPass(32'h2210_0000, 2'd2, 32'h1234_5678);
    passRd(32'h2210_0000, "R3 past window read");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule